// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Sticky Parity

This block recovers characters from an asynchronous serial line. An external rate generator supplies one enable pulse per oversample period, sixteen per bit time. The receiver waits for a falling edge and confirms the start bit at its midpoint. It then samples each following bit at its centre and assembles the character least significant bit first. The host sees the character together with status flags for parity, framing and break.

Line-control inputs select the character format:
- 5 to 8 data bits;
- an optional parity slot, checked as even, odd or a fixed sticky value;
- one or two stop bits.

Sticky parity lets a multi-drop link mark address characters with a fixed parity-slot value. A line held at 0 for a whole character is reported as a break. The host clears the flags with a read strobe. A line-status interrupt is raised only while its enable input is set.

Top module: `serial_char_receiver`

## Requirements
- R1: `wordLen` selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits. The bits are received least significant first and presented right-aligned on `rxData` with the unused upper bits 0. `dataReady` is set when the character is loaded.
- R2: A falling edge is confirmed by sampling at the 8th oversample tick. A 1 at that sample abandons the character, and nothing is loaded.
- R3: With `parityOn`=1 and `stickOn`=0, parity covers only the configured data bits. With `evenSel`=1 the total count of ones in the data bits and the parity slot must be even. With `evenSel`=0 it must be odd. Otherwise `parityErr` is set.
- R4: With `parityOn`=1 and `stickOn`=1, the parity-slot bit must equal the inverse of `evenSel`, so 1 is expected when `evenSel`=0. Any other value sets `parityErr`.
- R5: With `parityOn`=0 there is no parity slot, `stickOn` has no effect, and `parityErr` stays 0.
- R6: A 0 sampled in the first stop bit sets `frameErr`. A second stop bit selected by `twoStop`=1 is timed but not checked.
- R7: If every data, parity and first-stop sample of a frame is 0, `breakFlag` and `frameErr` are set and `rxData` is loaded with 0. Only one character is loaded per break. Reception resumes once the line has returned to 1.
- R8: A `readStrobe` pulse clears `dataReady`, `parityErr`, `frameErr` and `breakFlag`. The flags otherwise hold their values.
- R9: `lineIrq` is 1 exactly when `lsIntEn` is 1 and at least one of `parityErr`, `frameErr` or `breakFlag` is 1.
- R10: The receiver advances only on cycles with `sampleTick`=1, using 16 ticks per bit. Spacing the ticks out stretches the bit time without changing the result.
- R11: After reset, `dataReady`, all error flags, `lineIrq` and `rxData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Oversample enable, 16 per bit |
| rxIn | input | 1 | Serial line, idle high |
| wordLen | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parityOn | input | 1 | Parity slot present |
| evenSel | input | 1 | 1 = even parity, 0 = odd |
| stickOn | input | 1 | Fixed parity-slot value (inverse of evenSel) |
| twoStop | input | 1 | Two stop bits |
| lsIntEn | input | 1 | Line-status interrupt enable |
| readStrobe | input | 1 | Host read, clears status |
| rxData | output | 8 | Received character |
| dataReady | output | 1 | Character available |
| parityErr | output | 1 | Parity error |
| frameErr | output | 1 | Framing error |
| breakFlag | output | 1 | Break detected |
| lineIrq | output | 1 | Line-status interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit data width, 16 oversample ticks per bit and a two-stage input synchronizer. With these values every word length and the sticky, even, odd and no-parity modes are covered by one table of frames. A directed case spaces the ticks three clocks apart to show that only the tick rate sets the bit time. Further directed cases cover a false start, a break held well beyond one character, and interrupt gating.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic clearFrame;
    logic shiftData;
    logic takeParity;
    logic commit;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2, ST_HOLD
  } rxState_t;

  function automatic logic [3:0] dataBits(input logic [1:0] wordLen);
    return 4'd5 + {2'b00, wordLen};
  endfunction
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic [1:0] wordLen,
  input  logic       parityOn,
  input  logic       twoStop,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  rxState_t state, stateNext;
  logic [CNT_W-1:0] tickCnt, tickCntNext;
  logic [3:0] bitIdx, bitIdxNext;
  logic [3:0] nBits;

  assign nBits = dataBits(wordLen);

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    bitIdxNext  = bitIdx;
    strobe      = '0;
    if (sampleTick) begin
      unique case (state)
        ST_IDLE: if (!rxLine) begin
          stateNext   = ST_START;
          tickCntNext = '0;
        end
        ST_START: begin
          tickCntNext = tickCnt + 1'b1;
          if (tickCnt == MID) begin
            tickCntNext = '0;
            if (rxLine) stateNext = ST_IDLE;
            else begin
              stateNext         = ST_DATA;
              bitIdxNext        = '0;
              strobe.clearFrame = 1'b1;
            end
          end
        end
        ST_DATA: begin
          tickCntNext = tickCnt + 1'b1;
          if (tickCnt == LAST) begin
            tickCntNext      = '0;
            strobe.shiftData = 1'b1;
            bitIdxNext       = bitIdx + 1'b1;
            if (bitIdx == nBits - 1'b1) stateNext = parityOn ? ST_PARITY : ST_STOP1;
          end
        end
        ST_PARITY: begin
          tickCntNext = tickCnt + 1'b1;
          if (tickCnt == LAST) begin
            tickCntNext       = '0;
            strobe.takeParity = 1'b1;
            stateNext         = ST_STOP1;
          end
        end
        ST_STOP1: begin
          tickCntNext = tickCnt + 1'b1;
          if (tickCnt == LAST) begin
            tickCntNext   = '0;
            strobe.commit = 1'b1;
            if (!rxLine)      stateNext = ST_HOLD;
            else if (twoStop) stateNext = ST_STOP2;
            else              stateNext = ST_IDLE;
          end
        end
        ST_STOP2: begin
          tickCntNext = tickCnt + 1'b1;
          if (tickCnt == LAST) begin
            tickCntNext = '0;
            stateNext   = ST_IDLE;
          end
        end
        default: if (rxLine) stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      bitIdx  <= bitIdxNext;
    end
  end
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  rxStrobe_t         strobe,
  input  logic [1:0]        wordLen,
  input  logic              parityOn,
  input  logic              evenSel,
  input  logic              stickOn,
  input  logic              readStrobe,
  output logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakFlag
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic [DATA_W-1:0] shiftReg;
  logic parAcc, parBit, allZero;
  logic [3:0] nBits;
  logic [DATA_W-1:0] alignedData;
  logic slotValue, newParErr, newFrameErr, newBreak;

  assign rxLine = syncReg[SYNC_STAGES-1];
  assign nBits  = dataBits(wordLen);
  assign alignedData = shiftReg >> (4'(DATA_W) - nBits);

  // Even/odd: data ones plus slot; sticky: slot alone. Both must equal ~evenSel.
  assign slotValue   = stickOn ? parBit : (parAcc ^ parBit);
  assign newParErr   = parityOn && (slotValue != ~evenSel);
  assign newFrameErr = !rxLine;
  assign newBreak    = allZero && !rxLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
      allZero  <= 1'b1;
    end else if (strobe.clearFrame) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
      allZero  <= 1'b1;
    end else if (strobe.shiftData) begin
      shiftReg <= {rxLine, shiftReg[DATA_W-1:1]};
      parAcc   <= parAcc ^ rxLine;
      allZero  <= allZero & ~rxLine;
    end else if (strobe.takeParity) begin
      parBit  <= rxLine;
      allZero <= allZero & ~rxLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      dataReady <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakFlag <= 1'b0;
    end else if (strobe.commit) begin
      rxData    <= alignedData;
      dataReady <= 1'b1;
      parityErr <= (parityErr & ~readStrobe) | newParErr;
      frameErr  <= (frameErr  & ~readStrobe) | newFrameErr;
      breakFlag <= (breakFlag & ~readStrobe) | newBreak;
    end else if (readStrobe) begin
      dataReady <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_char_receiver.sv
module serial_char_receiver
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxIn,
  input  logic [1:0]        wordLen,
  input  logic              parityOn,
  input  logic              evenSel,
  input  logic              stickOn,
  input  logic              twoStop,
  input  logic              lsIntEn,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakFlag,
  output logic              lineIrq
);
  rxStrobe_t strobe;
  logic rxLine;

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .wordLen(wordLen), .parityOn(parityOn), .twoStop(twoStop), .strobe(strobe)
  );

  serial_rx_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strobe(strobe), .wordLen(wordLen),
    .parityOn(parityOn), .evenSel(evenSel), .stickOn(stickOn),
    .readStrobe(readStrobe), .rxLine(rxLine), .rxData(rxData),
    .dataReady(dataReady), .parityErr(parityErr), .frameErr(frameErr),
    .breakFlag(breakFlag)
  );

  assign lineIrq = lsIntEn & (parityErr | frameErr | breakFlag);
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleTick,
  input logic              readStrobe,
  input logic              lsIntEn,
  input logic [DATA_W-1:0] rxData,
  input logic              dataReady,
  input logic              parityErr,
  input logic              frameErr,
  input logic              breakFlag,
  input logic              lineIrq
);
  // R9: interrupt is silent while disabled
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    !lsIntEn |-> !lineIrq);

  // R9: an enabled break always interrupts
  p_irq_on_break_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lsIntEn && breakFlag) |-> lineIrq);

  // R8: a read with no tick in flight clears all status
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !sampleTick) |=> (!dataReady && !parityErr && !frameErr && !breakFlag));

  // R8: without read or tick the status holds
  p_status_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!readStrobe && !sampleTick) |=> ($stable(dataReady) && $stable(parityErr)
                                      && $stable(frameErr) && $stable(breakFlag)));

  // R10: a character can only arrive on a tick
  p_load_on_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(sampleTick));

  // R7: a break loads zero data and a framing error
  p_break_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakFlag) |-> (rxData == '0 && frameErr));
endmodule

bind serial_char_receiver serial_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .readStrobe(readStrobe),
  .lsIntEn(lsIntEn), .rxData(rxData), .dataReady(dataReady),
  .parityErr(parityErr), .frameErr(frameErr), .breakFlag(breakFlag),
  .lineIrq(lineIrq)
);

// File: tb/tb_serial_char_receiver.sv
`timescale 1ns/1ps
module tb_serial_char_receiver;
  logic clk = 1'b0, rstN = 1'b0, sampleTick = 1'b0, rxIn = 1'b1;
  logic [1:0] wordLen = 2'd3;
  logic parityOn = 0, evenSel = 0, stickOn = 0, twoStop = 0, lsIntEn = 1, readStrobe = 0;
  logic [7:0] rxData;
  logic dataReady, parityErr, frameErr, breakFlag, lineIrq;
  int checks = 0, fails = 0, tickDiv = 1, tickPh = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_char_receiver dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxIn(rxIn), .wordLen(wordLen),
    .parityOn(parityOn), .evenSel(evenSel), .stickOn(stickOn), .twoStop(twoStop),
    .lsIntEn(lsIntEn), .readStrobe(readStrobe), .rxData(rxData), .dataReady(dataReady),
    .parityErr(parityErr), .frameErr(frameErr), .breakFlag(breakFlag), .lineIrq(lineIrq)
  );

  always @(posedge clk) begin
    if (tickPh >= tickDiv - 1) begin tickPh <= 0; sampleTick <= 1'b1; end
    else begin tickPh <= tickPh + 1; sampleTick <= 1'b0; end
  end

  // {wordLen, parityOn, evenSel, stickOn, twoStop, data, flipParity, stopValue, expPe, expFe}
  localparam logic [17:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3D, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h4B, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxIn = b;
    waitClk(16 * tickDiv);
  endtask

  function automatic logic [7:0] maskData(input logic [1:0] wl, input logic [7:0] d);
    return d & ((8'd1 << (5 + wl)) - 8'd1);
  endfunction

  task automatic sendFrame(input logic [1:0] wl, input logic pen, eps, sp, stb,
                           input logic [7:0] d, input logic flip, stopv);
    logic [7:0] m = maskData(wl, d);
    logic par = sp ? ~eps : (eps ? ^m : ~^m);
    wordLen = wl; parityOn = pen; evenSel = eps; stickOn = sp; twoStop = stb;
    sendBit(1'b0);
    for (int i = 0; i < 5 + wl; i++) sendBit(m[i]);
    if (pen) sendBit(par ^ flip);
    sendBit(stopv);
    if (stb) sendBit(1'b1);
    sendBit(1'b1);
    sendBit(1'b1);
  endtask

  task automatic readPulse();
    readStrobe = 1'b1;
    waitClk(1);
    readStrobe = 1'b0;
    waitClk(1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    waitClk(4);
    chk("R11 dataReady", dataReady, 0);
    chk("R11 flags", {parityErr, frameErr, breakFlag}, 0);
    chk("R11 lineIrq", lineIrq, 0);
    chk("R11 rxData", rxData, 0);
    rstN = 1'b1;
    waitClk(40);

    foreach (VEC[k]) begin
      logic [17:0] v = VEC[k];
      sendFrame(v[17:16], v[15], v[14], v[13], v[12], v[11:4], v[3], v[2]);
      chk("R1 dataReady", dataReady, 1);
      chk("R1 rxData", rxData, maskData(v[17:16], v[11:4]));
      chk("R3 R4 R5 parityErr", parityErr, v[1]);
      chk("R6 frameErr", frameErr, v[0]);
      chk("R7 no break", breakFlag, 0);
      chk("R9 lineIrq", lineIrq, v[1] | v[0]);
      readPulse();
      chk("R8 cleared", {dataReady, parityErr, frameErr, breakFlag}, 0);
    end

    // R2: short glitch is not a start bit
    wordLen = 2'd3; parityOn = 0; stickOn = 0; twoStop = 0;
    rxIn = 1'b0; waitClk(3); rxIn = 1'b1; waitClk(300);
    chk("R2 false start ignored", dataReady, 0);
    sendFrame(2'd3, 0, 0, 0, 0, 8'h5A, 0, 1);
    chk("R2 next frame data", rxData, 8'h5A);
    readPulse();

    // R9: error without enable raises no interrupt
    lsIntEn = 1'b0;
    sendFrame(2'd3, 1, 1, 0, 0, 8'h17, 1, 1);
    chk("R9 parityErr set", parityErr, 1);
    chk("R9 irq masked", lineIrq, 0);
    lsIntEn = 1'b1; waitClk(1);
    chk("R9 irq enabled", lineIrq, 1);
    readPulse();

    // R7: break held for several character times
    wordLen = 2'd3; parityOn = 1; evenSel = 1; stickOn = 0;
    rxIn = 1'b0; waitClk(250);
    chk("R7 break data ready", dataReady, 1);
    chk("R7 break flag", breakFlag, 1);
    chk("R7 break frameErr", frameErr, 1);
    chk("R7 break data zero", rxData, 0);
    readPulse();
    waitClk(400);
    chk("R7 single char per break", dataReady, 0);
    rxIn = 1'b1; waitClk(40);
    sendFrame(2'd3, 0, 0, 0, 0, 8'h6E, 0, 1);
    chk("R7 resume data", rxData, 8'h6E);
    chk("R7 resume flags", {parityErr, frameErr, breakFlag}, 0);
    readPulse();

    // R10: ticks every third clock
    tickDiv = 3; waitClk(10);
    sendFrame(2'd3, 1, 0, 0, 0, 8'hC3, 0, 1);
    chk("R10 slow tick ready", dataReady, 1);
    chk("R10 slow tick data", rxData, 8'hC3);
    chk("R10 slow tick parity", parityErr, 0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule